// File: doc/BRIEF.md
# Two-Wire Humidity/Temperature Measurement Sequencer

This block runs one complete measurement on a humidity and temperature sensor that sits on a two-wire link with a clock line and a data line. A pulse on `start` latches the measurement kind from `mode`. The block then shifts out a command byte and checks that the sensor accepts it. It polls the data line until the sensor signals that the conversion is finished, and then clocks in a three-byte answer. The first two bytes form a 16-bit result. The third is a checksum, which the block stores without checking it.

The clock line is driven push-pull. The data line is open-drain: the block only ever pulls it low, through `sda_oe`, and reads the resolved level back on `sda_in`. Every phase of a bit is counted in system clocks. The count is derived from a clocks-per-microsecond parameter, so one source serves any system clock. Problems are reported as a small error count. A missing command acknowledge adds one. A conversion that never completes adds one and ends the run early.

Top module: `sensor_meas_seq`

## Requirements
- R1: After reset, `busy`, `done`, `scl_out`, `sda_oe`, `error_count`, `value` and `checksum` are all zero.
- R2: Mode 0 sends command `CMD_TEMP` (default 8'h03) and mode 1 sends `CMD_HUMI` (default 8'h05), most significant bit first. The mode is latched at start, and later changes of the `mode` input have no effect on the run.
- R3: Every clock-high phase lasts `HIGH_US*CLK_PER_US` cycles. The master changes `sda_oe` only while the clock is low, at least `SETUP_US*CLK_PER_US` cycles before a rise and at least `HOLD_US*CLK_PER_US` cycles after a fall.
- R4: After the eighth command bit the master releases data and gives a ninth clock. If data is high during that clock, `error_count` goes up by one.
- R5: Modes 2 and 3 send no command. No clock pulses occur before polling, so a full run has exactly 27 clock pulses.
- R6: After the command, the block polls `sda_in` until it is low. If data is still high after `TIMEOUT_US*CLK_PER_US` cycles of polling, `error_count` goes up by one and the run ends with no read clocks. In that case `value` and `checksum` keep their previous contents.
- R7: The first byte read becomes `value[15:8]`, the second `value[7:0]` and the third `checksum`. Each byte is sampled MSB first while the clock is high.
- R8: On the ninth clock of the first and second read bytes the master holds data low (acknowledge). On the ninth clock of the third byte it leaves data released.
- R9: `error_count` is cleared when a run starts, never decreases within a run, and saturates at 3.
- R10: `done` is high for exactly one cycle at the end of every run, including a run that ends on timeout, and `busy` is low while `done` is high. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement when idle |
| mode | input | 2 | 0 temperature, 1 humidity, 2/3 no command |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| value | output | 16 | Measured value, first byte high |
| checksum | output | 8 | Third byte received |
| error_count | output | 2 | Saturating error count for the last run |
| scl_out | output | 1 | Push-pull sensor clock |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_in | input | 1 | Resolved data line level |

## Verification
A wrong bit or byte counter shows directly in the number of clock pulses per run, which is 36, 27 or 9. It also shows as shifted or swapped bytes in `value` and `checksum`, and the error appears as soon as `done` pulses. A wrong phase counter shows within the first bit, as a clock-high width or data setup/hold spacing that differs from the configured microseconds. An error in the acknowledge or timeout path shows as a wrong `error_count`, as a missing or misplaced acknowledge seen by the sensor model, or as a timeout run whose length is not close to the polling limit.

// File: rtl/sensor_meas_seq.sv
module sensor_meas_seq #(
  parameter int        CLK_PER_US = 100,
  parameter int        SETUP_US   = 2,
  parameter int        HIGH_US    = 5,
  parameter int        HOLD_US    = 2,
  parameter int        TIMEOUT_US = 2_000_000,
  parameter logic [7:0] CMD_TEMP  = 8'h03,
  parameter logic [7:0] CMD_HUMI  = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  output logic        busy,
  output logic        done,
  output logic [15:0] value,
  output logic [7:0]  checksum,
  output logic [1:0]  error_count,
  output logic        scl_out,
  output logic        sda_oe,
  input  logic        sda_in
);

  localparam int SETUP_CYC = SETUP_US * CLK_PER_US;
  localparam int HIGH_CYC  = HIGH_US * CLK_PER_US;
  localparam int HOLD_CYC  = HOLD_US * CLK_PER_US;
  localparam int WAIT_CYC  = TIMEOUT_US * CLK_PER_US;
  localparam int PMAX = (SETUP_CYC > HIGH_CYC) ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                                               : ((HIGH_CYC > HOLD_CYC) ? HIGH_CYC : HOLD_CYC);
  localparam int TW = $clog2(PMAX + 1);
  localparam int WW = $clog2(WAIT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_FIN} st_t;
  typedef enum logic [1:0] {P_SETUP, P_HIGH, P_HOLD} ph_t;

  st_t         st;
  ph_t         ph;
  logic [TW-1:0] tcnt;
  logic [WW-1:0] wcnt;
  logic [3:0]  bitno;
  logic [1:0]  byteno;
  logic [7:0]  sh;

  wire       shifting = (st == S_TX) || (st == S_RX);
  wire       ack_slot = (bitno == 4'd8);
  wire [1:0] err_inc  = (error_count == 2'd3) ? 2'd3 : error_count + 2'd1;

  assign scl_out = shifting && (ph == P_HIGH);
  assign sda_oe  = (st == S_TX && !ack_slot && !sh[7]) ||
                   (st == S_RX && ack_slot && byteno != 2'd2);
  assign busy    = shifting || (st == S_WAIT);
  assign done    = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= P_SETUP;  tcnt <= '0;  wcnt <= '0;
      bitno <= '0;   byteno <= '0;   sh <= '0;
      value <= '0;   checksum <= '0; error_count <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          error_count <= '0;
          bitno <= '0;  byteno <= '0;  wcnt <= '0;
          ph <= P_SETUP;  tcnt <= TW'(SETUP_CYC - 1);
          if (mode == 2'd0)      begin sh <= CMD_TEMP; st <= S_TX; end
          else if (mode == 2'd1) begin sh <= CMD_HUMI; st <= S_TX; end
          else                   st <= S_WAIT;
        end
        S_TX, S_RX: begin
          if (tcnt != '0) tcnt <= tcnt - 1'b1;
          else case (ph)
            P_SETUP: begin ph <= P_HIGH; tcnt <= TW'(HIGH_CYC - 1); end
            P_HIGH: begin
              ph <= P_HOLD;  tcnt <= TW'(HOLD_CYC - 1);
              if (ack_slot) begin
                if (st == S_TX && sda_in) error_count <= err_inc;
              end else if (st == S_RX) sh <= {sh[6:0], sda_in};
            end
            default: begin
              ph <= P_SETUP;  tcnt <= TW'(SETUP_CYC - 1);
              if (ack_slot) begin
                bitno <= '0;
                if (st == S_TX) begin
                  st <= S_WAIT;  wcnt <= '0;
                end else begin
                  case (byteno)
                    2'd0:    value[15:8] <= sh;
                    2'd1:    value[7:0]  <= sh;
                    default: checksum    <= sh;
                  endcase
                  if (byteno == 2'd2) st <= S_FIN;
                  else byteno <= byteno + 2'd1;
                end
              end else begin
                bitno <= bitno + 4'd1;
                if (st == S_TX) sh <= {sh[6:0], 1'b0};
              end
            end
          endcase
        end
        S_WAIT: begin
          if (!sda_in) begin
            st <= S_RX;  ph <= P_SETUP;  tcnt <= TW'(SETUP_CYC - 1);
            bitno <= '0; byteno <= '0;
          end else if (wcnt == WW'(WAIT_CYC - 1)) begin
            error_count <= err_inc;
            st <= S_FIN;
          end else wcnt <= wcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (scl_out) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  a_r3_scl_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> hi_cnt == (TW+1)'(HIGH_CYC));
  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl_out && $past(scl_out) |-> $stable(sda_oe));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_out && !sda_oe);
  a_r9_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> error_count >= $past(error_count));

endmodule

// File: tb/sensor_meas_seq_tb.sv
module sensor_meas_seq_tb;
  localparam int CPU = 2, SU = 2, HU = 5, DU = 2, TU = 200;
  localparam int HIGH_CYC = HU * CPU;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode = 0;
  logic busy, done, scl_out, sda_oe;
  logic [15:0] value;
  logic [7:0] checksum;
  logic [1:0] error_count;
  logic pull = 0;
  wire  sda = ~(sda_oe | pull);

  always #2 clk = ~clk;

  sensor_meas_seq #(.CLK_PER_US(CPU), .SETUP_US(SU), .HIGH_US(HU), .HOLD_US(DU),
                    .TIMEOUT_US(TU)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy), .done(done),
    .value(value), .checksum(checksum), .error_count(error_count),
    .scl_out(scl_out), .sda_oe(sda_oe), .sda_in(sda));

  typedef struct packed {
    logic [1:0] mode; logic nack; logic [15:0] dly;
    logic [7:0] msb; logic [7:0] lsb; logic [7:0] crc;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 16'd50,     8'hA5, 8'h3C, 8'h7E},
    '{2'd1, 1'b0, 16'd10,     8'hFF, 8'h00, 8'h81},
    '{2'd0, 1'b1, 16'd30,     8'h12, 8'h34, 8'h56},
    '{2'd1, 1'b0, 16'hFFFF,   8'h99, 8'h99, 8'h99},
    '{2'd2, 1'b0, 16'd20,     8'h00, 8'hFF, 8'h01},
    '{2'd1, 1'b1, 16'hFFFF,   8'h77, 8'h77, 8'h77},
    '{2'd3, 1'b0, 16'd5,      8'h80, 8'h01, 8'hC3},
    '{2'd0, 1'b0, 16'd1,      8'h7F, 8'hFE, 8'h00}
  };

  int n_chk = 0, n_fail = 0;
  int scl_rises, tbad, done_w, hi_len, since_oe, since_fall, cycles;
  logic last_scl = 0, last_oe = 0, busy_at_done;
  logic [7:0] cmd_seen;
  logic [2:0] ack_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    hi_len = 0; since_oe = 100; since_fall = 100; tbad = 0; scl_rises = 0; done_w = 0;
    busy_at_done = 0;
  end

  always @(negedge clk) begin
    if (scl_out && !last_scl) begin
      scl_rises++;
      if (since_oe < SU * CPU - 2) tbad++;
    end
    if (!scl_out && last_scl) begin
      if (hi_len != HIGH_CYC) tbad++;
    end
    if (sda_oe != last_oe) begin
      if (scl_out || last_scl) tbad++;
      else if (since_fall < DU * CPU - 2) tbad++;
    end
    hi_len     = scl_out ? hi_len + 1 : 0;
    since_fall = (!scl_out && last_scl) ? 0 : since_fall + 1;
    since_oe   = (sda_oe != last_oe) ? 0 : since_oe + 1;
    if (done) begin done_w++; if (busy) busy_at_done = 1; end
    last_scl = scl_out;
    last_oe  = sda_oe;
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_rise();
    while (scl_out) @(negedge clk);
    while (!scl_out) @(negedge clk);
  endtask
  task automatic wait_fall();
    while (!scl_out) @(negedge clk);
    while (scl_out) @(negedge clk);
  endtask

  task automatic sensor(input vec_t v);
    logic [7:0] b;
    if (v.mode < 2) begin
      for (int i = 0; i < 8; i++) begin wait_rise(); cmd_seen = {cmd_seen[6:0], sda}; end
      wait_fall();
      pull = !v.nack;
      wait_rise();
      wait_fall();
      pull = 0;
    end
    if (v.dly == 16'hFFFF) return;
    repeat (v.dly) @(negedge clk);
    pull = 1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      b = (k == 0) ? v.msb : (k == 1) ? v.lsb : v.crc;
      for (int i = 7; i >= 0; i--) begin pull = ~b[i]; wait_rise(); wait_fall(); end
      pull = 0;
      wait_rise();
      ack_seen[k] = ~sda;
      wait_fall();
    end
  endtask

  task automatic run(input vec_t v, input bit poke);
    scl_rises = 0; tbad = 0; done_w = 0; busy_at_done = 0; cmd_seen = 0; ack_seen = 0;
    mode = v.mode; start = 1;
    @(negedge clk);
    start = 0; cycles = 1;
    fork
      sensor(v);
      begin
        while (!done) begin
          @(negedge clk); cycles++;
          if (poke && cycles == 40) begin mode = 2'd2; start = 1; end
          if (poke && cycles == 41) start = 0;
        end
      end
    join
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] pv;
    logic [7:0]  pc;
    logic        tmo;
    repeat (3) @(negedge clk);
    chk("R1 reset", {busy, done, scl_out, sda_oe, error_count, value, checksum}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {busy, done, scl_out, sda_oe}, 0);
    pv = 0; pc = 0;
    for (int n = 0; n < NV; n++) begin
      vec_t v;
      v = VECS[n];
      tmo = (v.dly == 16'hFFFF);
      run(v, 0);
      if (!tmo) begin pv = {v.msb, v.lsb}; pc = v.crc; end
      chk($sformatf("R4 R6 R9 err v%0d", n), error_count,
          32'((v.mode < 2 && v.nack) ? 1 : 0) + 32'(tmo ? 1 : 0));
      chk($sformatf("R7 R6 value v%0d", n), value, pv);
      chk($sformatf("R7 R6 checksum v%0d", n), checksum, pc);
      chk($sformatf("R5 R6 clocks v%0d", n), scl_rises,
          (v.mode < 2 ? 9 : 0) + (tmo ? 0 : 27));
      if (v.mode < 2) chk($sformatf("R2 cmd v%0d", n), cmd_seen, v.mode == 0 ? 8'h03 : 8'h05);
      if (!tmo) chk($sformatf("R8 acks v%0d", n), ack_seen, 3'b011);
      if (tmo && v.mode < 2)
        chk($sformatf("R6 timeout length v%0d", n), (cycles >= 561 && cycles <= 565), 1);
      chk($sformatf("R3 timing v%0d", n), tbad, 0);
      chk($sformatf("R10 done v%0d", n), {done_w[7:0], busy_at_done}, {8'd1, 1'b0});
    end
    run(VECS[0], 1);
    chk("R10 start while busy ignored: clocks", scl_rises, 36);
    chk("R2 mode latched at start", cmd_seen, 8'h03);
    chk("R10 busy restart value", value, 16'hA53C);
    chk("R9 cleared err", error_count, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule